// File: doc/BRIEF.md
# FPU Status and Exception Unit

This block holds the 32-bit floating-point status word of a scalar FPU. Software loads the whole word with a control write. From that word the block decodes the rounding mode and the flush-to-zero mode for the downstream arithmetic unit. It also supplies the canonical quiet NaN patterns for single and double precision.

When the arithmetic unit completes an operation, it strobes `op_done` and presents a five-bit raw exception vector. The block places each raw bit at the position of its enable bit and moves the result up into the sticky flag field with a fixed shift. In the same clock edge it raises a one-cycle trap request if any raised exception has its enable bit set. An operation that reports no exception leaves the word untouched.

The update logic selects one of three actions each cycle: HOLD (keep the word), LOAD (a control write replaces the word) or MERGE (an operation ORs new flags in). LOAD has priority over MERGE. MERGE applies only when the operation reports at least one exception.

Top module: `fpsr_unit`

## Requirements
- R1: Status bits 10:9 select the rounding mode, and `round_sel` is one-hot: value 0 gives bit 0 (nearest even), 1 gives bit 1 (toward zero), 2 gives bit 2 (toward plus infinity), 3 gives bit 3 (toward minus infinity).
- R2: Status bit 5 drives `flush_results`, `flush_inputs` and `tiny_pre_round` together. All three are 1 when the bit is set and 0 when it is clear.
- R3: Raw exception bit k maps to enable bit 4-k and flag bit 31-k. Raw bit 0 is invalid (enable 4, flag 31), bit 1 divide-by-zero (3, 30), bit 2 overflow (2, 29), bit 3 underflow (1, 28) and bit 4 inexact (0, 27).
- R4: An `op_done` with an all-zero exception vector leaves the status word unchanged. `op_exc` has no effect while `op_done` is low.
- R5: Flags are sticky. A merge ORs the new flags into bits 31:27 and never clears a flag or changes bits 26:0.
- R6: A control write replaces all 32 bits in the next cycle. It wins over a same-cycle `op_done`, whose flags are dropped and which raises no trap.
- R7: `trap_req` is high for exactly the cycle after an `op_done` whose mapped exceptions overlap the enable bits (4:0) in force at that time. Otherwise it is low.
- R8: `dnan_single` is 0x7FC00000 and `dnan_double` is 0x7FF8000000000000: sign clear, exponent all ones, only the top fraction bit set.
- R9: After reset the status word is 0 and `trap_req` is 0, so `round_sel` is 4'b0001 and flushing is off.
- R10: A trap depends only on the exceptions of the current operation. Flags already set from earlier operations raise no trap, even when their enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | New status word |
| op_done | input | 1 | Operation completed this cycle |
| op_exc | input | 5 | Raw exceptions: 0 invalid, 1 div-zero, 2 overflow, 3 underflow, 4 inexact |
| status_word | output | 32 | Current status word |
| round_sel | output | 4 | One-hot rounding mode |
| flush_results | output | 1 | Flush tiny results to zero |
| flush_inputs | output | 1 | Flush tiny inputs to zero |
| tiny_pre_round | output | 1 | Tininess for flushing judged before rounding |
| trap_req | output | 1 | One-cycle trap request |
| dnan_single | output | 32 | Default single-precision NaN |
| dnan_double | output | 64 | Default double-precision NaN |

## Verification
The assertions check four rules on every cycle: `round_sel` stays one-hot, flags never fall outside a control write, a quiet operation holds the word, and a control write lands intact and suppresses the trap. They also check that every trap pulse follows an operation that reported an exception without a colliding write. Only the bench scenarios can show the bit mapping from raw exceptions to flag and enable positions, and that a trap ignores older sticky flags. The same holds for the exact default NaN patterns and the decode of each rounding-mode value.

// File: rtl/fpsr_pkg.sv
`timescale 1ns/1ps
package fpsr_pkg;

    localparam int unsigned FPSR_W   = 32;
    localparam int unsigned NUM_EXC  = 5;
    localparam int unsigned EN_LSB   = 0;
    localparam int unsigned FLAG_LSB = 27;
    localparam int unsigned DCTL_BIT = 5;
    localparam int unsigned RM_LSB   = 9;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_TO_PINF   = 2'd2,
        RM_TO_NINF   = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_LOAD  = 2'd1,
        UPD_MERGE = 2'd2
    } upd_e;

    // raw index k sits at enable position (NUM_EXC-1-k)
    function automatic int unsigned en_pos(input int unsigned raw_idx);
        return NUM_EXC - 1 - raw_idx;
    endfunction

endpackage

// File: rtl/fpsr_mode_decode.sv
`timescale 1ns/1ps
module fpsr_mode_decode
    import fpsr_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned RM_POS   = 9,
    parameter int unsigned DCTL_POS = 5
) (
    input  logic [WORD_W-1:0] word,
    output logic [3:0]        round_sel,
    output logic              flush_res,
    output logic              flush_in,
    output logic              tiny_pre
);

    rmode_e mode;

    always_comb begin
        mode = rmode_e'(word[RM_POS +: 2]);
        unique case (mode)
            RM_NEAR_EVEN: round_sel = 4'b0001;
            RM_TO_ZERO:   round_sel = 4'b0010;
            RM_TO_PINF:   round_sel = 4'b0100;
            RM_TO_NINF:   round_sel = 4'b1000;
            default:      round_sel = 4'b0001;
        endcase
    end

    // one control bit flushes results and inputs; tininess judged pre-rounding
    always_comb begin
        flush_res = word[DCTL_POS];
        flush_in  = word[DCTL_POS];
        tiny_pre  = word[DCTL_POS];
    end

endmodule

// File: rtl/fpsr_exc_map.sv
`timescale 1ns/1ps
module fpsr_exc_map
    import fpsr_pkg::*;
#(
    parameter int unsigned N_EXC = 5
) (
    input  logic [N_EXC-1:0] raw,
    output logic [N_EXC-1:0] en_order
);

    for (genvar k = 0; k < N_EXC; k++) begin : g_map
        assign en_order[N_EXC-1-k] = raw[k];
    end

endmodule

// File: rtl/fpsr_dnan.sv
`timescale 1ns/1ps
module fpsr_dnan #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned TOT_W = 1 + EXP_W + FRAC_W
) (
    output logic [TOT_W-1:0] nan_out
);

    assign nan_out = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

endmodule

// File: rtl/fpsr_update.sv
`timescale 1ns/1ps
module fpsr_update
    import fpsr_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_EXC   = 5,
    parameter int unsigned EN_POS  = 0,
    parameter int unsigned FLG_POS = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [WORD_W-1:0] ctl_wdata,
    input  logic              op_done,
    input  logic [N_EXC-1:0]  exc_en_order,
    output logic [WORD_W-1:0] word_q,
    output logic              trap_q
);

    localparam int unsigned SHIFT = FLG_POS - EN_POS;

    upd_e              kind;
    logic [WORD_W-1:0] hard_at_en;
    logic [WORD_W-1:0] flag_ins;
    logic              trap_hit;

    always_comb begin
        hard_at_en = WORD_W'(exc_en_order) << EN_POS;
        flag_ins   = hard_at_en << SHIFT;
        trap_hit   = |(hard_at_en & word_q);
        if (ctl_we)
            kind = UPD_LOAD;
        else if (op_done && (|exc_en_order))
            kind = UPD_MERGE;
        else
            kind = UPD_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            trap_q <= 1'b0;
        end else begin
            trap_q <= 1'b0;
            unique case (kind)
                UPD_LOAD:  word_q <= ctl_wdata;
                UPD_MERGE: begin
                    word_q <= word_q | flag_ins;
                    trap_q <= trap_hit;
                end
                UPD_HOLD:  word_q <= word_q;
                default:   word_q <= word_q;
            endcase
        end
    end

    p_load_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_we) |-> (word_q == $past(ctl_wdata) && !trap_q));

    p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctl_we) && ($past(exc_en_order) == '0 || !$past(op_done)))
        |-> word_q == $past(word_q));

    p_sticky_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_we) |-> (((word_q & $past(word_q)) == $past(word_q))
                            && (word_q[FLG_POS-1:0] == $past(word_q[FLG_POS-1:0]))));

    p_trap_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> ($past(op_done) && !$past(ctl_we) && $past(exc_en_order) != '0));

endmodule

// File: rtl/fpsr_unit.sv
`timescale 1ns/1ps
module fpsr_unit
    import fpsr_pkg::*;
#(
    parameter int unsigned WORD_W   = FPSR_W,
    parameter int unsigned N_EXC    = NUM_EXC,
    parameter int unsigned EN_POS   = EN_LSB,
    parameter int unsigned FLG_POS  = FLAG_LSB,
    parameter int unsigned DCTL_POS = DCTL_BIT,
    parameter int unsigned RM_POS   = RM_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [WORD_W-1:0] ctl_wdata,
    input  logic              op_done,
    input  logic [N_EXC-1:0]  op_exc,
    output logic [WORD_W-1:0] status_word,
    output logic [3:0]        round_sel,
    output logic              flush_results,
    output logic              flush_inputs,
    output logic              tiny_pre_round,
    output logic              trap_req,
    output logic [31:0]       dnan_single,
    output logic [63:0]       dnan_double
);

    logic [N_EXC-1:0] exc_en_order;

    fpsr_exc_map #(.N_EXC(N_EXC)) u_map (
        .raw      (op_exc),
        .en_order (exc_en_order)
    );

    fpsr_update #(
        .WORD_W (WORD_W),
        .N_EXC  (N_EXC),
        .EN_POS (EN_POS),
        .FLG_POS(FLG_POS)
    ) u_upd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .ctl_wdata   (ctl_wdata),
        .op_done     (op_done),
        .exc_en_order(exc_en_order),
        .word_q      (status_word),
        .trap_q      (trap_req)
    );

    fpsr_mode_decode #(
        .WORD_W  (WORD_W),
        .RM_POS  (RM_POS),
        .DCTL_POS(DCTL_POS)
    ) u_dec (
        .word     (status_word),
        .round_sel(round_sel),
        .flush_res(flush_results),
        .flush_in (flush_inputs),
        .tiny_pre (tiny_pre_round)
    );

    fpsr_dnan #(.EXP_W(8),  .FRAC_W(23)) u_nan_sp (.nan_out(dnan_single));
    fpsr_dnan #(.EXP_W(11), .FRAC_W(52)) u_nan_dp (.nan_out(dnan_double));

    p_round_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(round_sel) == 1);

    p_flush_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_we) |-> (flush_results == $past(ctl_wdata[DCTL_POS])
                           && flush_inputs == $past(ctl_wdata[DCTL_POS])));

endmodule

// File: tb/test_fpsr_unit.sv
`timescale 1ns/1ps
module test_fpsr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic [31:0] status_word;
    logic [3:0]  round_sel;
    logic        flush_results, flush_inputs, tiny_pre_round, trap_req;
    logic [31:0] dnan_single;
    logic [63:0] dnan_double;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_word = '0;
    logic        m_trap = 1'b0;

    always #2.5 clk = ~clk;

    fpsr_unit i_fpsr_unit (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .op_done(op_done), .op_exc(op_exc), .status_word(status_word),
        .round_sel(round_sel), .flush_results(flush_results),
        .flush_inputs(flush_inputs), .tiny_pre_round(tiny_pre_round),
        .trap_req(trap_req), .dnan_single(dnan_single), .dnan_double(dnan_double)
    );

    function automatic logic [4:0] map_raw(input logic [4:0] r);
        logic [4:0] m;
        for (int k = 0; k < 5; k++) m[4-k] = r[k];
        return m;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(input logic we, input logic [31:0] wd, input logic dn,
                        input logic [4:0] ex, input string tag);
        logic [4:0] m;
        ctl_we = we; ctl_wdata = wd; op_done = dn; op_exc = ex;
        if (we) begin
            m_word = wd; m_trap = 1'b0;
        end else if (dn && ex != 5'd0) begin
            m = map_raw(ex);
            m_trap = |(m & m_word[4:0]);
            m_word = m_word | ({27'd0, m} << 27);
        end else begin
            m_trap = 1'b0;
        end
        @(negedge clk);
        ctl_we = 1'b0; op_done = 1'b0; op_exc = '0;
        check({tag, " word"}, 64'(status_word), 64'(m_word));
        check("R7 trap", 64'(trap_req), 64'(m_trap));
        check("R1 round_sel", 64'(round_sel), 64'(4'b0001 << m_word[10:9]));
        check("R2 flush", 64'({flush_results, flush_inputs, tiny_pre_round}),
              64'({3{m_word[5]}}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check("R9 word", 64'(status_word), 64'd0);
        check("R9 trap", 64'(trap_req), 64'd0);
        check("R9 round", 64'(round_sel), 64'h1);
        // R8 default NaNs
        check("R8 single", 64'(dnan_single), 64'h7FC00000);
        check("R8 double", dnan_double, 64'h7FF8000000000000);
        // R1 each rounding value
        for (int v = 0; v < 4; v++) step(1'b1, 32'(v) << 9, 1'b0, 5'd0, "R1");
        // R2 flush on and off
        step(1'b1, 32'h0000_0020, 1'b0, 5'd0, "R2");
        step(1'b1, 32'h0000_0000, 1'b0, 5'd0, "R2");
        // R3 mapping per raw bit, without and with matching enable
        for (int k = 0; k < 5; k++) begin
            step(1'b1, 32'd0, 1'b0, 5'd0, "R3");
            step(1'b0, 32'd0, 1'b1, 5'(1 << k), "R3");
            check("R3 flagpos", 64'(status_word), 64'(32'd1 << (31 - k)));
            step(1'b1, 32'd1 << (4 - k), 1'b0, 5'd0, "R3");
            step(1'b0, 32'd0, 1'b1, 5'(1 << k), "R3");
            check("R3 trap", 64'(trap_req), 64'd1);
        end
        // R7 pulse falls after one cycle
        step(1'b0, 32'd0, 1'b0, 5'd0, "R7");
        check("R7 pulse end", 64'(trap_req), 64'd0);
        // R4 quiet op and ignored op_exc
        step(1'b1, 32'h0000_061F, 1'b0, 5'd0, "R4");
        step(1'b0, 32'd0, 1'b1, 5'd0, "R4");
        step(1'b0, 32'd0, 1'b0, 5'b11111, "R4");
        check("R4 ignored", 64'(status_word), 64'h061F);
        // R5 sticky accumulation
        step(1'b1, 32'h0000_0000, 1'b0, 5'd0, "R5");
        step(1'b0, 32'd0, 1'b1, 5'b00001, "R5");
        step(1'b0, 32'd0, 1'b1, 5'b10000, "R5");
        step(1'b0, 32'd0, 1'b1, 5'b00001, "R5");
        check("R5 both", 64'(status_word), 64'h8800_0000);
        // R6 write beats same-cycle op
        step(1'b1, 32'h0000_001F, 1'b0, 5'd0, "R6");
        step(1'b1, 32'h0000_0240, 1'b1, 5'b11111, "R6");
        check("R6 no trap", 64'(trap_req), 64'd0);
        // R10 old enabled flag does not trap a new non-enabled exception
        step(1'b1, 32'h8000_0010, 1'b0, 5'd0, "R10");
        step(1'b0, 32'd0, 1'b1, 5'b10000, "R10");
        check("R10 no trap", 64'(trap_req), 64'd0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic we, dn;
            logic [4:0] ex;
            we = ($urandom % 8) == 0;
            dn = $urandom % 2;
            ex = (($urandom % 3) == 0) ? 5'd0 : 5'($urandom % 32);
            step(we, $urandom, dn, ex, we ? "R6" : ((dn && ex != 0) ? "R5" : "R4"));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule